// File: doc/BRIEF.md
# Paired-Alias Control and Status Register Bank

This block holds a group of 32-bit control and status registers behind a simple memory-mapped register bus. Each register has two word addresses. A write to the lower one clears bits and a write to the upper one sets bits. Only the bit positions written as one change, so software can flip a single flag without first reading the register. A read at either address returns the same contents.

On the hardware side, each register has a vector of set pulses. A pulse forces its bit to one, and it takes priority over a host clear of the same bit in the same cycle, so no event is lost. Every register's value is driven out continuously to the logic around the bank.

The bus accepts one request per cycle and never stalls. There is no ready signal, so the host issues a request whenever it wants and the bank applies no back-pressure. Read data comes back one cycle after the request, marked by `rsp_valid`. An access that decodes to no register is reported on `bus_err` one cycle after the request.

Top module: `sc_alias_bank`

## Requirements
- R1: Register k (0 to NUM_REGS-1) has its clear alias at byte address 8*k and its set alias at 8*k+4. An address with bit 1 or bit 0 set is misaligned and selects no register.
- R2: A write to the clear alias of register k makes zero every bit of k whose write-data bit is one. The other bits keep their value. The change is visible on `reg_q` after the next rising edge.
- R3: A write to the set alias of register k makes one every bit of k whose write-data bit is one. The other bits keep their value. The change is visible on `reg_q` after the next rising edge.
- R4: A read at either alias of register k sets `rsp_valid` high in the following cycle only. In that cycle, `rsp_rdata` equals the value register k held in the cycle of the request.
- R5: A one on a bit of `hw_set` makes that register bit one after the next edge. This holds even if a host clear of that same bit is made in the same cycle.
- R6: An access that is misaligned or at or beyond byte address 8*NUM_REGS changes no register. It raises `bus_err` for exactly the next cycle. If the access is a read, it returns zero with `rsp_valid`.
- R7: While `rst` is high at a rising edge, all registers become zero and `rsp_valid` and `bus_err` become low.
- R8: Without a host write or a hardware set aimed at it, a register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data, a bit mask for both aliases |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W | Read data |
| bus_err | output | 1 | Pulses one cycle after an access that decodes to no register |
| hw_set | input | NUM_REGS*DATA_W | Hardware set pulses, register k in bits [k*DATA_W +: DATA_W] |
| reg_q | output | NUM_REGS*DATA_W | Current register contents, same packing as hw_set |

## Verification
The hardest case to reach from the ports is a host clear and a hardware set landing on the same bit of the same register in the same edge. This is where the priority rule decides whether an event survives. Directed steps create it on purpose with a full-mask clear against a one-bit pulse. The random phase aims its hardware pulses at the register the host is addressing in half of the cycles. This drives many overlapping masks through the collision path and through the set-alias path at the same time.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;

  // Which of the two aliases an address selects (address bit 2).
  typedef enum logic {
    ALIAS_CLR = 1'b0,
    ALIAS_SET = 1'b1
  } alias_e;

  // Byte offset of the set alias relative to the clear alias.
  localparam int unsigned SET_OFFSET = 4;
  // Byte stride between register pairs.
  localparam int unsigned PAIR_STRIDE = 8;
  // Low address bits that select the pair (log2 of the stride).
  localparam int unsigned PAIR_SHIFT = 3;

  // Decoded access class.
  typedef struct packed {
    logic   hit;
    logic   miss;
    logic   is_wr;
    alias_e which;
  } access_t;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sc_bank_decode.sv
module sc_bank_decode
  import sc_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] clr_sel,
  output logic [NUM_REGS-1:0] set_sel,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                rd_hit,
  output logic                rd_req,
  output logic                miss
);

  localparam int unsigned PAGE_W = ADDR_W - PAIR_SHIFT;

  logic [PAGE_W-1:0] page;
  logic              aligned;
  logic              in_range;
  access_t           acc;

  always_comb begin
    page      = addr[ADDR_W-1:PAIR_SHIFT];
    aligned   = (addr[1:0] == 2'b00);
    in_range  = ({{(32-PAGE_W){1'b0}}, page} < NUM_REGS);
    acc.hit   = req && aligned && in_range;
    acc.miss  = req && !(aligned && in_range);
    acc.is_wr = we;
    acc.which = alias_e'(addr[2]);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    logic page_match;
    assign page_match = (page == PAGE_W'(g));
    assign clr_sel[g] = acc.hit && acc.is_wr && page_match && (acc.which == ALIAS_CLR);
    assign set_sel[g] = acc.hit && acc.is_wr && page_match && (acc.which == ALIAS_SET);
  end

  assign rd_idx = page[IDX_W-1:0];
  assign rd_hit = acc.hit && !acc.is_wr;
  assign rd_req = req && !we;
  assign miss   = acc.miss;

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_sel, set_sel}));

  // R6
  miss_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    miss |-> ({clr_sel, set_sel} == '0) && !rd_hit);

endmodule

// File: rtl/sc_bank_cell.sv
module sc_bank_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] q_nxt;

  // Hardware set is ORed last so it overrides a same-cycle host clear.
  always_comb begin
    clr_mask = clr_en ? wdata : '0;
    set_mask = set_en ? wdata : '0;
    q_nxt    = (q & ~clr_mask) | set_mask | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // R2
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((q & $past(wdata & ~hw_set)) == '0));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((q & $past(wdata)) == $past(wdata)));

  // R5
  hw_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && !set_en && (hw_set == '0)) |=> $stable(q));

endmodule

// File: rtl/sc_bank_rdpath.sv
module sc_bank_rdpath #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_req,
  input  logic                       rd_hit,
  input  logic                       miss,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       err
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] sel_val;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign regs[g] = regs_flat[g*DATA_W +: DATA_W];
  end

  // AND-OR select; an index past the bank picks nothing.
  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_hit && (rd_idx == IDX_W'(i))) sel_val = sel_val | regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= sel_val;
      err       <= miss;
    end
  end

  // R4
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  // R6
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (err && rsp_valid) |-> (rsp_rdata == '0));

  // R6
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !miss |=> !err);

endmodule

// File: rtl/sc_alias_bank.sv
module sc_alias_bank
  import sc_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       bus_err,
  input  logic [NUM_REGS*DATA_W-1:0] hw_set,
  output logic [NUM_REGS*DATA_W-1:0] reg_q
);

  localparam int unsigned IDX_W = idx_width(NUM_REGS);

  logic [NUM_REGS-1:0] clr_sel;
  logic [NUM_REGS-1:0] set_sel;
  logic [IDX_W-1:0]    rd_idx;
  logic                rd_hit;
  logic                rd_req;
  logic                miss;

  sc_bank_decode #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_decode (
    .clk    (clk),
    .rst    (rst),
    .req    (bus_req),
    .we     (bus_we),
    .addr   (bus_addr),
    .clr_sel(clr_sel),
    .set_sel(set_sel),
    .rd_idx (rd_idx),
    .rd_hit (rd_hit),
    .rd_req (rd_req),
    .miss   (miss)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    sc_bank_cell #(.DATA_W(DATA_W)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .clr_en(clr_sel[g]),
      .set_en(set_sel[g]),
      .wdata (bus_wdata),
      .hw_set(hw_set[g*DATA_W +: DATA_W]),
      .q     (reg_q[g*DATA_W +: DATA_W])
    );
  end

  sc_bank_rdpath #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
  ) u_rdpath (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_hit   (rd_hit),
    .miss     (miss),
    .rd_idx   (rd_idx),
    .regs_flat(reg_q),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .err      (bus_err)
  );

  // R6
  miss_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && miss && (hw_set == '0)) |=> $stable(reg_q));

  // R7
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !bus_err));

endmodule

// File: tb/sc_alias_bank_test.sv
module sc_alias_bank_test;

  localparam int N  = 8;
  localparam int W  = 32;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_req = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [W-1:0]    bus_wdata = '0;
  logic            rsp_valid;
  logic [W-1:0]    rsp_rdata;
  logic            bus_err;
  logic [N*W-1:0]  hw_set = '0;
  logic [N*W-1:0]  reg_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [W-1:0] m [N];
  logic         exp_rv;
  logic [W-1:0] exp_rd;
  logic         exp_err;

  always #5 clk = ~clk;

  sc_alias_bank #(.NUM_REGS(N), .DATA_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_err(bus_err), .hw_set(hw_set), .reg_q(reg_q)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Address decode per R1: hit when aligned and below 8*N.
  function automatic bit addr_hit(input logic [AW-1:0] a);
    return (a[1:0] == 2'b00) && (int'(a) < 8 * N);
  endfunction

  task automatic check_regs(input string req);
    for (int k = 0; k < N; k++) chk(req, reg_q[k*W +: W], m[k]);
  endtask

  // One bus cycle: drive after the falling edge, update the model,
  // then sample 1 ns after the rising edge.
  task automatic step(input bit req, input bit we, input logic [AW-1:0] a,
                      input logic [W-1:0] wd, input logic [N*W-1:0] hw,
                      input string tag);
    int idx;
    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd; hw_set = hw;
    idx = int'(a) / 8;
    exp_rv  = req && !we;
    exp_rd  = (req && !we && addr_hit(a)) ? m[idx] : '0;
    exp_err = req && !addr_hit(a);
    if (req && we && addr_hit(a)) begin
      if (a[2]) m[idx] = m[idx] | wd;
      else      m[idx] = m[idx] & ~wd;
    end
    for (int k = 0; k < N; k++) m[k] = m[k] | hw[k*W +: W];
    @(posedge clk);
    #1;
    chk({tag, " rsp_valid"}, W'(rsp_valid), W'(exp_rv));
    if (exp_rv) chk({tag, " rsp_rdata"}, rsp_rdata, exp_rd);
    chk({tag, " bus_err"}, W'(bus_err), W'(exp_err));
    check_regs({tag, " reg_q"});
  endtask

  function automatic logic [AW-1:0] clr_a(input int k); return AW'(8 * k); endfunction
  function automatic logic [AW-1:0] set_a(input int k); return AW'(8 * k + 4); endfunction

  function automatic logic [N*W-1:0] one_hw(input int k, input logic [W-1:0] v);
    logic [N*W-1:0] r;
    r = '0;
    r[k*W +: W] = v;
    return r;
  endfunction

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h5eed_c0de);
    for (int k = 0; k < N; k++) m[k] = '0;

    // R7: reset state, with hardware pulses present during reset
    hw_set = '1;
    repeat (3) @(posedge clk);
    #1;
    check_regs("R7 reset");
    chk("R7 rsp_valid in reset", W'(rsp_valid), '0);
    chk("R7 bus_err in reset", W'(bus_err), '0);
    @(negedge clk);
    hw_set = '0;
    rst = 1'b0;

    // R3: set alias of register 2
    step(1, 1, set_a(2), 32'hA5A5_0F0F, '0, "R3 set");
    // R2: clear alias removes only written ones
    step(1, 1, clr_a(2), 32'h0000_0F00, '0, "R2 clear");
    // R4: both aliases read the same contents
    step(1, 0, clr_a(2), '0, '0, "R4 read clr alias");
    step(1, 0, set_a(2), '0, '0, "R4 read set alias");
    // R4: read of the last register
    step(1, 1, set_a(N-1), 32'hFFFF_FFFF, '0, "R3 set last");
    step(1, 0, clr_a(N-1), '0, '0, "R4 read last");
    // R5: hardware set wins over a full clear on the same bits
    step(1, 1, clr_a(N-1), 32'hFFFF_FFFF, one_hw(N-1, 32'h0000_0100), "R5 collision");
    step(1, 0, set_a(N-1), '0, '0, "R5 readback");
    // R6: write beyond the bank is ignored
    step(1, 1, AW'(8 * N), 32'hFFFF_FFFF, '0, "R6 write past end");
    step(1, 1, AW'(8 * N + 4), 32'hFFFF_FFFF, '0, "R6 set past end");
    // R6 / R1: misaligned write and read
    step(1, 1, 8'h15, 32'hFFFF_FFFF, '0, "R1 misaligned write");
    step(1, 0, 8'h06, '0, '0, "R6 misaligned read");
    step(1, 0, 8'hF0, '0, '0, "R6 read past end");
    // R8: idle cycles hold
    step(0, 0, '0, '0, '0, "R8 idle");
    step(0, 1, set_a(0), 32'hFFFF_FFFF, '0, "R8 no req");
    // R5: pulse alone
    step(0, 0, '0, '0, one_hw(0, 32'h8000_0001), "R5 pulse only");

    // Constrained random phase
    for (int c = 0; c < 3000; c++) begin
      logic [AW-1:0]  a;
      logic [W-1:0]   wd;
      logic [N*W-1:0] hw;
      int sel;
      int k;
      sel = int'($urandom_range(0, 9));
      k   = int'($urandom_range(0, N-1));
      if (sel < 7)      a = AW'(8 * k + 4 * int'($urandom_range(0, 1)));
      else if (sel < 9) a = AW'(8 * k + int'($urandom_range(1, 3)));
      else              a = AW'($urandom_range(8 * N, 255));
      wd = $urandom() & $urandom();
      hw = '0;
      if ($urandom_range(0, 1) == 1) hw = one_hw(k, $urandom() & $urandom() & $urandom());
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, wd, hw,
           "R2 R3 R4 R5 R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule